// File: doc/BRIEF.md
# DMA Channel Control Register Unit

This block holds the per-channel control and status registers of a descriptor-driven DMA controller. A 32-bit, word-access, memory-mapped bus reaches every channel through its own 8 KiB window. The window number selects the channel. Bits [7:2] of the address select a register inside the window. Each channel keeps pointer registers, a configuration register, a three-state channel machine, an interrupt block (raw events, a mask, an acknowledge path and an interrupt line), and two command registers.

Writes to the command registers are not acted on here. They are decoded into single-cycle request pulses for a separate descriptor engine. That engine reports back through a set of per-channel event inputs:

- it has started the channel;
- it has reached the end of the list;
- interrupt events have occurred;
- the command source has changed;
- new pointer values are available.

The unit does no memory traffic of its own.

Top module: `dma_chan_regs`

## Requirements
- R1: The channel index is address bits [13+] and the register index is address bits [7:2]. The byte offsets are: 0x00 current data pointer, 0x58 saved pointer, 0x5C saved buffer pointer, 0x60 group pointer, 0x7C context pointer, 0x80 command, 0x84 configuration, 0x88 status, 0x8C mask, 0x90 acknowledge, 0x94 raw interrupt, 0x98 masked interrupt and 0x9C stream command. Any other offset reads 0 and ignores writes. Read data is combinational from the address.
- R2: The five pointer registers are 32-bit read/write. An engine pointer update loads the current data pointer and the saved buffer pointer. A bus write to the same register in the same cycle wins.
- R3: The configuration register stores the whole written word. Bit 0 is enable and bit 1 is stop. When the register is written, enable=0 forces the state to RESET (code 1). Otherwise stop=1 forces STOPPED (code 2). Otherwise the state is unchanged. An engine start moves the state to RUNNING (code 4) only when the stored configuration is enabled and not stopped, and no configuration write happens in that cycle. State codes are one-hot.
- R4: A status read returns the state code in [2:0], the end-of-list flag in bit 5, the command source in [15:8] and the error flag in bit 16. Writes to the status register are ignored.
- R5: An engine end-of-list event sets the end-of-list flag. An accepted engine start clears it. If both happen in the same cycle, the event wins.
- R6: Engine interrupt events are ORed into the raw register, which is INTR_W bits wide. An acknowledge write clears the raw bits where the written data is 1, but an event in the same cycle still sets its bit. The acknowledge register reads back 0. The raw and masked registers are read-only.
- R7: The mask keeps the low INTR_W bits of the written data. The masked register and the interrupt line follow raw AND mask, one clock after any change to either.
- R8: A stream-command write stores data bits [9:0]. In the cycle after the write, a data-load request pulses if any bit of 0x140 is set. A start request pulses as well if bit 0x20 is also set. A context-load request pulses if bit 0x200 is set.
- R9: A command write stores data bit 0. In the next cycle it pulses the continue request, but only if the channel was enabled, not stopped and RUNNING, and the engine's descriptor end-of-list input was high in the write cycle.
- R10: A command write with any bit set in [31:1], or a stream-command write with any bit set in [31:10], sets a sticky error flag (status bit 16). The legal field of the value is still stored.
- R11: After reset every register reads 0, except the status register, which reads 0x00000001. All request pulses and the interrupt line are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W | Byte address (channel window and register offset) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| eng_start | input | NUM_CH | Engine starts the channel |
| eng_eol | input | NUM_CH | Engine reached the end of the list |
| eng_desc_eol | input | NUM_CH | End-of-list bit of the current data descriptor |
| eng_intr | input | NUM_CH x INTR_W | Interrupt event bits per channel |
| eng_src_we | input | NUM_CH | Load the command-source field |
| eng_src | input | 8 | Command-source value |
| eng_ptr_we | input | NUM_CH | Load the data and buffer pointers |
| eng_data_ptr | input | 32 | New current data pointer |
| eng_buf_ptr | input | 32 | New saved buffer pointer |
| req_load_data | output | NUM_CH | Data-descriptor load request pulse |
| req_start | output | NUM_CH | Start-after-load request pulse |
| req_load_ctx | output | NUM_CH | Context-descriptor load request pulse |
| req_continue | output | NUM_CH | Continue request pulse |
| irq | output | NUM_CH | Channel interrupt line |

## Verification
The hardest event to reach is the continue pulse, because four things must all hold in the write cycle:

- the channel is enabled;
- it is not stopped;
- the state machine has reached RUNNING, which takes an engine start accepted under a clean configuration;
- the descriptor end-of-list input is high.

The bench first walks one channel there with a directed sequence and then checks the pulse against each of the gating conditions in turn. A long random phase follows. It biases configuration writes toward the enable-only value and drives engine starts, end-of-list events and interrupt events at random, so collisions appear in many combinations: acknowledge against new events, configuration writes against starts, and pointer writes against engine updates. A behavioural model checks every one of those cycles.

// File: rtl/dma_chreg_pkg.sv
package dma_chreg_pkg;

  localparam int WIN_BITS = 13;
  localparam int SRC_W    = 8;

  localparam logic [5:0] IX_CUR_PTR = 6'd0;
  localparam logic [5:0] IX_SV_PTR  = 6'd22;
  localparam logic [5:0] IX_SV_BUF  = 6'd23;
  localparam logic [5:0] IX_GRP     = 6'd24;
  localparam logic [5:0] IX_GRP_DN  = 6'd31;
  localparam logic [5:0] IX_CMD     = 6'd32;
  localparam logic [5:0] IX_CFG     = 6'd33;
  localparam logic [5:0] IX_STAT    = 6'd34;
  localparam logic [5:0] IX_MASK    = 6'd35;
  localparam logic [5:0] IX_ACK     = 6'd36;
  localparam logic [5:0] IX_RAW     = 6'd37;
  localparam logic [5:0] IX_MSKD    = 6'd38;
  localparam logic [5:0] IX_STRM    = 6'd39;

  typedef enum logic [2:0] {
    CH_RESET   = 3'b001,
    CH_STOPPED = 3'b010,
    CH_RUNNING = 3'b100
  } ch_state_e;

  typedef struct packed {
    logic ld_data;
    logic start;
    logic ld_ctx;
  } strm_req_t;

  function automatic logic [31:0] pack_status(ch_state_e st, logic eol,
                                              logic [SRC_W-1:0] src, logic err);
    logic [31:0] w;
    w        = '0;
    w[2:0]   = st;
    w[5]     = eol;
    w[15:8]  = src;
    w[16]    = err;
    return w;
  endfunction

  function automatic strm_req_t decode_stream(logic [9:0] w);
    strm_req_t r;
    r.ld_data = |(w & 10'h140);
    r.start   = r.ld_data & w[5];
    r.ld_ctx  = w[9];
    return r;
  endfunction

  function automatic logic stream_bad(logic [31:0] w);
    return |w[31:10];
  endfunction

  function automatic logic cmd_bad(logic [31:0] w);
    return |w[31:1];
  endfunction

endpackage

// File: rtl/dma_chreg_fsm.sv
module dma_chreg_fsm
  import dma_chreg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_wr,
  input  logic      new_en,
  input  logic      new_stop,
  input  logic      cur_en,
  input  logic      cur_stop,
  input  logic      eng_start,
  input  logic      eng_eol,
  output ch_state_e state,
  output logic      eol
);

  logic start_ok;
  assign start_ok = eng_start && !cfg_wr && cur_en && !cur_stop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= CH_RESET;
      eol   <= 1'b0;
    end else begin
      if (cfg_wr) begin
        if (!new_en)
          state <= CH_RESET;
        else if (new_stop)
          state <= CH_STOPPED;
      end else if (start_ok) begin
        state <= CH_RUNNING;
      end
      if (eng_eol)
        eol <= 1'b1;
      else if (start_ok)
        eol <= 1'b0;
    end
  end

  AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state) == 1); // R3
  AST_DISABLE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && !new_en |=> state == CH_RESET); // R3
  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && new_en && new_stop |=> state == CH_STOPPED); // R3
  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start && !cfg_wr && cur_en && !cur_stop && !eng_eol
      |=> state == CH_RUNNING && !eol); // R5
  AST_EOL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    eol && !eng_start |=> eol); // R5

endmodule

// File: rtl/dma_chreg_irq.sv
module dma_chreg_irq #(
  parameter int INTR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr,
  input  logic              ack_wr,
  input  logic [INTR_W-1:0] wbits,
  input  logic [INTR_W-1:0] set_bits,
  output logic [INTR_W-1:0] raw,
  output logic [INTR_W-1:0] mask,
  output logic [INTR_W-1:0] masked,
  output logic              irq
);

  function automatic logic [INTR_W-1:0] raw_after(logic [INTR_W-1:0] cur,
                                                  logic [INTR_W-1:0] clr,
                                                  logic [INTR_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  logic [INTR_W-1:0] clr_bits;
  logic [INTR_W-1:0] raw_nx;
  logic [INTR_W-1:0] mask_nx;

  assign clr_bits = ack_wr ? wbits : '0;
  assign raw_nx   = raw_after(raw, clr_bits, set_bits);
  assign mask_nx  = mask_wr ? wbits : mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw    <= '0;
      mask   <= '0;
      masked <= '0;
    end else begin
      raw    <= raw_nx;
      mask   <= mask_nx;
      masked <= raw_nx & mask_nx;
    end
  end

  assign irq = |masked;

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> (raw & $past(wbits & ~set_bits)) == '0); // R6
  AST_EVENT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    |set_bits |=> (raw & $past(set_bits)) == $past(set_bits)); // R6
  AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (masked & ~mask) == '0); // R7
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(raw & mask)) == irq); // R7

endmodule

// File: rtl/dma_chreg_cmd.sv
module dma_chreg_cmd
  import dma_chreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic        strm_wr,
  input  logic [31:0] wdata,
  input  ch_state_e   state,
  input  logic        cur_en,
  input  logic        cur_stop,
  input  logic        desc_eol,
  output logic        cmd_bit,
  output logic [9:0]  strm_val,
  output logic        err,
  output logic        req_ld_data,
  output logic        req_start,
  output logic        req_ld_ctx,
  output logic        req_cont
);

  strm_req_t dec;
  logic      cont_ok;

  assign dec     = decode_stream(wdata[9:0]);
  assign cont_ok = cur_en && !cur_stop && (state == CH_RUNNING) && desc_eol;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_bit     <= 1'b0;
      strm_val    <= '0;
      err         <= 1'b0;
      req_ld_data <= 1'b0;
      req_start   <= 1'b0;
      req_ld_ctx  <= 1'b0;
      req_cont    <= 1'b0;
    end else begin
      req_ld_data <= strm_wr && dec.ld_data;
      req_start   <= strm_wr && dec.start;
      req_ld_ctx  <= strm_wr && dec.ld_ctx;
      req_cont    <= cmd_wr && cont_ok;
      if (strm_wr) begin
        strm_val <= wdata[9:0];
        if (stream_bad(wdata))
          err <= 1'b1;
      end
      if (cmd_wr) begin
        cmd_bit <= wdata[0];
        if (cmd_bad(wdata))
          err <= 1'b1;
      end
    end
  end

  AST_START_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    req_start |-> req_ld_data); // R8
  AST_LOAD_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ld_data || req_ld_ctx) |-> $past(strm_wr)); // R8
  AST_CONT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    req_cont |-> $past(state) == CH_RUNNING && $past(desc_eol) && $past(cmd_wr)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R10

endmodule

// File: rtl/dma_chreg_slice.sv
module dma_chreg_slice
  import dma_chreg_pkg::*;
#(
  parameter int INTR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic [5:0]        word_ix,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              eng_start,
  input  logic              eng_eol,
  input  logic              eng_desc_eol,
  input  logic [INTR_W-1:0] eng_intr,
  input  logic              eng_src_we,
  input  logic [SRC_W-1:0]  eng_src,
  input  logic              eng_ptr_we,
  input  logic [31:0]       eng_data_ptr,
  input  logic [31:0]       eng_buf_ptr,
  output logic              req_load_data,
  output logic              req_start,
  output logic              req_load_ctx,
  output logic              req_continue,
  output logic              irq
);

  localparam int PAD_W = 32 - INTR_W;

  logic [31:0]       cur_ptr, sv_ptr, sv_buf, grp_ptr, grpdn_ptr, cfg;
  logic [SRC_W-1:0]  src;
  ch_state_e         state;
  logic              eol, err, cmd_bit;
  logic [9:0]        strm_val;
  logic [INTR_W-1:0] raw, mask, masked;

  logic wr_cfg, wr_cmd, wr_strm, wr_mask, wr_ack;
  assign wr_cfg  = wr_sel && (word_ix == IX_CFG);
  assign wr_cmd  = wr_sel && (word_ix == IX_CMD);
  assign wr_strm = wr_sel && (word_ix == IX_STRM);
  assign wr_mask = wr_sel && (word_ix == IX_MASK);
  assign wr_ack  = wr_sel && (word_ix == IX_ACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_ptr   <= '0;
      sv_ptr    <= '0;
      sv_buf    <= '0;
      grp_ptr   <= '0;
      grpdn_ptr <= '0;
      cfg       <= '0;
      src       <= '0;
    end else begin
      if (eng_ptr_we) begin
        cur_ptr <= eng_data_ptr;
        sv_buf  <= eng_buf_ptr;
      end
      if (eng_src_we)
        src <= eng_src;
      if (wr_sel) begin
        case (word_ix)
          IX_CUR_PTR: cur_ptr   <= wdata;
          IX_SV_PTR:  sv_ptr    <= wdata;
          IX_SV_BUF:  sv_buf    <= wdata;
          IX_GRP:     grp_ptr   <= wdata;
          IX_GRP_DN:  grpdn_ptr <= wdata;
          IX_CFG:     cfg       <= wdata;
          default: ;
        endcase
      end
    end
  end

  dma_chreg_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (wr_cfg),
    .new_en    (wdata[0]),
    .new_stop  (wdata[1]),
    .cur_en    (cfg[0]),
    .cur_stop  (cfg[1]),
    .eng_start (eng_start),
    .eng_eol   (eng_eol),
    .state     (state),
    .eol       (eol)
  );

  dma_chreg_irq #(.INTR_W(INTR_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .mask_wr  (wr_mask),
    .ack_wr   (wr_ack),
    .wbits    (wdata[INTR_W-1:0]),
    .set_bits (eng_intr),
    .raw      (raw),
    .mask     (mask),
    .masked   (masked),
    .irq      (irq)
  );

  dma_chreg_cmd u_cmd (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr      (wr_cmd),
    .strm_wr     (wr_strm),
    .wdata       (wdata),
    .state       (state),
    .cur_en      (cfg[0]),
    .cur_stop    (cfg[1]),
    .desc_eol    (eng_desc_eol),
    .cmd_bit     (cmd_bit),
    .strm_val    (strm_val),
    .err         (err),
    .req_ld_data (req_load_data),
    .req_start   (req_start),
    .req_ld_ctx  (req_load_ctx),
    .req_cont    (req_continue)
  );

  always_comb begin
    case (word_ix)
      IX_CUR_PTR: rdata = cur_ptr;
      IX_SV_PTR:  rdata = sv_ptr;
      IX_SV_BUF:  rdata = sv_buf;
      IX_GRP:     rdata = grp_ptr;
      IX_GRP_DN:  rdata = grpdn_ptr;
      IX_CMD:     rdata = {31'd0, cmd_bit};
      IX_CFG:     rdata = cfg;
      IX_STAT:    rdata = pack_status(state, eol, src, err);
      IX_MASK:    rdata = {{PAD_W{1'b0}}, mask};
      IX_RAW:     rdata = {{PAD_W{1'b0}}, raw};
      IX_MSKD:    rdata = {{PAD_W{1'b0}}, masked};
      IX_STRM:    rdata = {22'd0, strm_val};
      default:    rdata = '0;
    endcase
  end

  AST_PTR_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel && word_ix == IX_SV_BUF |=> sv_buf == $past(wdata)); // R2

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chreg_pkg::*;
#(
  parameter  int NUM_CH = 2,
  parameter  int INTR_W = 4,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = WIN_BITS + CH_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [31:0]                    bus_wdata,
  output logic [31:0]                    bus_rdata,
  input  logic [NUM_CH-1:0]              eng_start,
  input  logic [NUM_CH-1:0]              eng_eol,
  input  logic [NUM_CH-1:0]              eng_desc_eol,
  input  logic [NUM_CH-1:0][INTR_W-1:0]  eng_intr,
  input  logic [NUM_CH-1:0]              eng_src_we,
  input  logic [SRC_W-1:0]               eng_src,
  input  logic [NUM_CH-1:0]              eng_ptr_we,
  input  logic [31:0]                    eng_data_ptr,
  input  logic [31:0]                    eng_buf_ptr,
  output logic [NUM_CH-1:0]              req_load_data,
  output logic [NUM_CH-1:0]              req_start,
  output logic [NUM_CH-1:0]              req_load_ctx,
  output logic [NUM_CH-1:0]              req_continue,
  output logic [NUM_CH-1:0]              irq
);

  logic [CH_W-1:0] ch_ix;
  logic            ch_ok;
  logic [5:0]      word_ix;
  logic            unused_addr_bits;
  logic [31:0]     slice_rdata [NUM_CH];

  assign ch_ix            = bus_addr[ADDR_W-1:WIN_BITS];
  assign ch_ok            = ({1'b0, ch_ix} < (CH_W+1)'(NUM_CH));
  assign word_ix          = bus_addr[7:2];
  assign unused_addr_bits = ^{bus_addr[WIN_BITS-1:8], bus_addr[1:0]};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic wr_sel;
    assign wr_sel = bus_wr && ch_ok && (ch_ix == CH_W'(g));

    dma_chreg_slice #(.INTR_W(INTR_W)) u_slice (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_sel        (wr_sel),
      .word_ix       (word_ix),
      .wdata         (bus_wdata),
      .rdata         (slice_rdata[g]),
      .eng_start     (eng_start[g]),
      .eng_eol       (eng_eol[g]),
      .eng_desc_eol  (eng_desc_eol[g]),
      .eng_intr      (eng_intr[g]),
      .eng_src_we    (eng_src_we[g]),
      .eng_src       (eng_src),
      .eng_ptr_we    (eng_ptr_we[g]),
      .eng_data_ptr  (eng_data_ptr),
      .eng_buf_ptr   (eng_buf_ptr),
      .req_load_data (req_load_data[g]),
      .req_start     (req_start[g]),
      .req_load_ctx  (req_load_ctx[g]),
      .req_continue  (req_continue[g]),
      .irq           (irq[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (ch_ok && ch_ix == CH_W'(i))
        bus_rdata = slice_rdata[i];
  end

  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(req_continue | req_load_data | req_load_ctx) <= 1); // R1

endmodule

// File: tb/test_dma_chan_regs.sv
`timescale 1ns/1ps
module test_dma_chan_regs;
  localparam int NUM_CH = 2;
  localparam int INTR_W = 4;
  localparam int AW     = 14;
  localparam logic [31:0] IMASK = 32'h0000000F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NUM_CH-1:0] eng_start = '0, eng_eol = '0, eng_desc_eol = '0;
  logic [NUM_CH-1:0][INTR_W-1:0] eng_intr = '0;
  logic [NUM_CH-1:0] eng_src_we = '0, eng_ptr_we = '0;
  logic [7:0] eng_src = '0;
  logic [31:0] eng_data_ptr = '0, eng_buf_ptr = '0;
  logic [NUM_CH-1:0] req_load_data, req_start, req_load_ctx, req_continue, irq;

  always #4 clk = ~clk;

  dma_chan_regs #(.NUM_CH(NUM_CH), .INTR_W(INTR_W)) i_dma_chan_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_start(eng_start),
    .eng_eol(eng_eol), .eng_desc_eol(eng_desc_eol), .eng_intr(eng_intr),
    .eng_src_we(eng_src_we), .eng_src(eng_src), .eng_ptr_we(eng_ptr_we),
    .eng_data_ptr(eng_data_ptr), .eng_buf_ptr(eng_buf_ptr),
    .req_load_data(req_load_data), .req_start(req_start),
    .req_load_ctx(req_load_ctx), .req_continue(req_continue), .irq(irq));

  int n_chk = 0;
  int n_bad = 0;
  bit checking = 1'b0;
  bit done = 1'b0;

  // Reference model state
  logic [31:0] m_cur [NUM_CH], m_svp [NUM_CH], m_svb [NUM_CH], m_grp [NUM_CH];
  logic [31:0] m_gdn [NUM_CH], m_cfg [NUM_CH], m_raw [NUM_CH], m_mask [NUM_CH];
  int          m_st [NUM_CH];
  logic [7:0]  m_src [NUM_CH];
  logic        m_eol [NUM_CH], m_err [NUM_CH], m_cmd [NUM_CH];
  logic [9:0]  m_strm [NUM_CH];
  logic        e_ld [NUM_CH], e_go [NUM_CH], e_ctx [NUM_CH], e_cont [NUM_CH];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_read(int ch, int ix);
    case (ix)
      0:  return m_cur[ch];
      22: return m_svp[ch];
      23: return m_svb[ch];
      24: return m_grp[ch];
      31: return m_gdn[ch];
      32: return {31'd0, m_cmd[ch]};
      33: return m_cfg[ch];
      34: return 32'(m_st[ch]) | (32'(m_eol[ch]) << 5) | (32'(m_src[ch]) << 8)
                 | (32'(m_err[ch]) << 16);
      35: return m_mask[ch];
      37: return m_raw[ch];
      38: return m_raw[ch] & m_mask[ch];
      39: return {22'd0, m_strm[ch]};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(int ix);
    case (ix)
      0, 22, 23, 24, 31: return "R2 pointer";
      33: return "R3 config";
      34: return "R4 R5 R10 status";
      36, 37: return "R6 raw/ack";
      35, 38: return "R7 mask";
      32, 39: return "R10 command store";
      default: return "R1 unused offset";
    endcase
  endfunction

  always @(posedge clk) begin : model
    if (!rst_n) begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        m_cur[ch] = 0; m_svp[ch] = 0; m_svb[ch] = 0; m_grp[ch] = 0; m_gdn[ch] = 0;
        m_cfg[ch] = 0; m_raw[ch] = 0; m_mask[ch] = 0; m_st[ch] = 1; m_src[ch] = 0;
        m_eol[ch] = 0; m_err[ch] = 0; m_cmd[ch] = 0; m_strm[ch] = 0;
        e_ld[ch] = 0; e_go[ch] = 0; e_ctx[ch] = 0; e_cont[ch] = 0;
      end
    end else begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        bit hit, start_ok;
        int ix, ost;
        logic [31:0] ocfg, clr;
        hit  = bus_wr && (int'(bus_addr >> 13) == ch);
        ix   = int'(bus_addr[7:2]);
        ocfg = m_cfg[ch];
        ost  = m_st[ch];
        e_ld[ch] = 0; e_go[ch] = 0; e_ctx[ch] = 0; e_cont[ch] = 0;
        start_ok = eng_start[ch] && !(hit && ix == 33) && ocfg[0] && !ocfg[1];
        if (hit && ix == 33) begin
          m_cfg[ch] = bus_wdata;
          if (!bus_wdata[0]) m_st[ch] = 1;
          else if (bus_wdata[1]) m_st[ch] = 2;
        end else if (start_ok) m_st[ch] = 4;
        if (eng_eol[ch]) m_eol[ch] = 1;
        else if (start_ok) m_eol[ch] = 0;
        if (eng_src_we[ch]) m_src[ch] = eng_src;
        if (eng_ptr_we[ch]) begin
          m_cur[ch] = eng_data_ptr;
          m_svb[ch] = eng_buf_ptr;
        end
        if (hit) begin
          if (ix == 0)  m_cur[ch] = bus_wdata;
          if (ix == 22) m_svp[ch] = bus_wdata;
          if (ix == 23) m_svb[ch] = bus_wdata;
          if (ix == 24) m_grp[ch] = bus_wdata;
          if (ix == 31) m_gdn[ch] = bus_wdata;
          if (ix == 35) m_mask[ch] = bus_wdata & IMASK;
        end
        clr = (hit && ix == 36) ? (bus_wdata & IMASK) : 32'd0;
        m_raw[ch] = (m_raw[ch] & ~clr) | 32'(eng_intr[ch]);
        if (hit && ix == 39) begin
          m_strm[ch] = bus_wdata[9:0];
          if (bus_wdata[31:10] != 0) m_err[ch] = 1;
          e_ld[ch]  = (bus_wdata & 32'h140) != 0;
          e_go[ch]  = e_ld[ch] && bus_wdata[5];
          e_ctx[ch] = bus_wdata[9];
        end
        if (hit && ix == 32) begin
          m_cmd[ch] = bus_wdata[0];
          if (bus_wdata[31:1] != 0) m_err[ch] = 1;
          e_cont[ch] = ocfg[0] && !ocfg[1] && ost == 4 && eng_desc_eol[ch];
        end
      end
    end
  end

  always @(negedge clk) begin : compare
    if (checking) begin
      int ch, ix;
      logic [31:0] ev;
      ch = int'(bus_addr >> 13);
      ix = int'(bus_addr[7:2]);
      ev = exp_read(ch, ix);
      chk(bus_rdata === ev, tag_of(ix), bus_rdata, ev);
      for (int c = 0; c < NUM_CH; c++) begin
        chk(irq[c] === |(m_raw[c] & m_mask[c]), "R7 irq", 32'(irq[c]),
            32'(|(m_raw[c] & m_mask[c])));
        chk(req_load_data[c] === e_ld[c], "R8 load-data", 32'(req_load_data[c]), 32'(e_ld[c]));
        chk(req_start[c] === e_go[c], "R8 start", 32'(req_start[c]), 32'(e_go[c]));
        chk(req_load_ctx[c] === e_ctx[c], "R8 load-ctx", 32'(req_load_ctx[c]), 32'(e_ctx[c]));
        chk(req_continue[c] === e_cont[c], "R9 continue", 32'(req_continue[c]), 32'(e_cont[c]));
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input int ch, input int off, input logic [31:0] d);
    bus_addr  = AW'((ch << 13) | off);
    bus_wdata = d;
    bus_wr    = 1'b1;
    tick();
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input int ch, input int off, output logic [31:0] d);
    bus_addr = AW'((ch << 13) | off);
    #1;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R11 watchdog act=%h exp=%h", 32'd0, 32'd1);
      finish_run();
    end
  end

  initial begin : stim
    logic [31:0] d;
    int offs [14] = '{'h00, 'h58, 'h5C, 'h60, 'h7C, 'h80, 'h84, 'h88, 'h8C,
                      'h90, 'h94, 'h98, 'h9C, 'hA4};
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R11 reset values
    rd(0, 'h88, d); chk(d == 32'h1, "R11 status ch0", d, 32'h1);
    rd(1, 'h88, d); chk(d == 32'h1, "R11 status ch1", d, 32'h1);
    rd(1, 'h84, d); chk(d == 32'h0, "R11 config", d, 32'h0);
    rd(0, 'h5C, d); chk(d == 32'h0, "R11 pointer", d, 32'h0);
    chk(irq == '0, "R11 irq", 32'(irq), 32'd0);
    checking = 1'b1;

    // R2 pointers and R1 decode
    wr(0, 'h00, 32'hA0A0_0000); wr(0, 'h58, 32'hA0A0_0058);
    wr(0, 'h5C, 32'hA0A0_005C); wr(0, 'h60, 32'hA0A0_0060);
    wr(0, 'h7C, 32'hA0A0_007C); wr(1, 'h5C, 32'hB1B1_005C);
    rd(1, 'h5C, d); chk(d == 32'hB1B1_005C, "R2 ch1 buffer ptr", d, 32'hB1B1_005C);
    rd(0, 'h5C, d); chk(d == 32'hA0A0_005C, "R1 ch0 kept apart", d, 32'hA0A0_005C);
    wr(1, 'hA0, 32'hFFFF_FFFF);
    rd(1, 'hA0, d); chk(d == 32'h0, "R1 unused offset", d, 32'h0);
    eng_ptr_we[0] = 1'b1; eng_data_ptr = 32'h1234_0000; eng_buf_ptr = 32'h1234_0040;
    wr(0, 'h5C, 32'hDEAD_BEEF);
    eng_ptr_we[0] = 1'b0;
    rd(0, 'h5C, d); chk(d == 32'hDEAD_BEEF, "R2 bus write wins", d, 32'hDEAD_BEEF);
    rd(0, 'h00, d); chk(d == 32'h1234_0000, "R2 engine data ptr", d, 32'h1234_0000);

    // R3 state machine
    wr(0, 'h84, 32'h1);
    rd(0, 'h88, d); chk(d[2:0] == 3'd1, "R3 enable alone keeps reset", d, 32'h1);
    eng_start[0] = 1'b1; tick(); eng_start[0] = 1'b0;
    rd(0, 'h88, d); chk(d[2:0] == 3'd4, "R3 start runs", d, 32'h4);
    wr(0, 'h84, 32'h3);
    rd(0, 'h88, d); chk(d[2:0] == 3'd2, "R3 stop", d, 32'h2);
    eng_start[0] = 1'b1; tick(); eng_start[0] = 1'b0;
    rd(0, 'h88, d); chk(d[2:0] == 3'd2, "R3 start ignored when stopped", d, 32'h2);
    wr(0, 'h84, 32'h2);
    rd(0, 'h88, d); chk(d[2:0] == 3'd1, "R3 disable beats stop", d, 32'h1);

    // R5 eol flag and R4 source
    wr(0, 'h84, 32'h1);
    eng_start[0] = 1'b1; tick(); eng_start[0] = 1'b0;
    eng_eol[0] = 1'b1; eng_src_we[0] = 1'b1; eng_src = 8'h5A; tick();
    eng_eol[0] = 1'b0; eng_src_we[0] = 1'b0;
    rd(0, 'h88, d); chk(d == 32'h5A24, "R5 eol in status", d, 32'h5A24);
    wr(0, 'h88, 32'hFFFF_FFFF);
    rd(0, 'h88, d); chk(d == 32'h5A24, "R4 status write ignored", d, 32'h5A24);

    // R6 R7 interrupts
    wr(0, 'h8C, 32'h5);
    eng_intr[0] = 4'h3; tick(); eng_intr[0] = '0;
    chk(irq[0] == 1'b1, "R7 irq raised", 32'(irq[0]), 32'd1);
    rd(0, 'h98, d); chk(d == 32'h1, "R7 masked value", d, 32'h1);
    wr(0, 'h90, 32'h1);
    chk(irq[0] == 1'b0, "R7 irq cleared by ack", 32'(irq[0]), 32'd0);
    rd(0, 'h94, d); chk(d == 32'h2, "R6 raw after ack", d, 32'h2);
    rd(0, 'h90, d); chk(d == 32'h0, "R6 ack reads zero", d, 32'h0);
    eng_intr[0] = 4'h2; wr(0, 'h90, 32'h2); eng_intr[0] = '0;
    rd(0, 'h94, d); chk(d == 32'h2, "R6 event beats ack", d, 32'h2);

    // R8 stream command
    wr(1, 'h9C, 32'h160);
    chk(req_load_data[1] && req_start[1], "R8 load and start", 32'(req_start[1]), 32'd1);
    tick();
    chk(req_start[1] == 1'b0, "R8 single pulse", 32'(req_start[1]), 32'd0);
    wr(1, 'h9C, 32'h020);
    chk(req_start[1] == 1'b0, "R8 start needs load", 32'(req_start[1]), 32'd0);
    wr(1, 'h9C, 32'h200);
    chk(req_load_ctx[1] == 1'b1, "R8 context load", 32'(req_load_ctx[1]), 32'd1);
    wr(1, 'h9C, 32'h0000_0440);
    rd(1, 'h88, d); chk(d[16] == 1'b1, "R10 stream error", d, 32'h10001);
    rd(1, 'h9C, d); chk(d == 32'h040, "R10 legal field kept", d, 32'h040);

    // R9 continue
    eng_desc_eol[0] = 1'b1; wr(0, 'h80, 32'h1);
    chk(req_continue[0] == 1'b1, "R9 continue forwarded", 32'(req_continue[0]), 32'd1);
    eng_desc_eol[0] = 1'b0; wr(0, 'h80, 32'h1);
    chk(req_continue[0] == 1'b0, "R9 blocked without eol", 32'(req_continue[0]), 32'd0);
    eng_desc_eol[1] = 1'b1; wr(1, 'h80, 32'h1); eng_desc_eol[1] = 1'b0;
    chk(req_continue[1] == 1'b0, "R9 blocked when not running", 32'(req_continue[1]), 32'd0);
    rd(0, 'h88, d); chk(d[16] == 1'b0, "R10 no error yet", d, 32'h0);
    wr(0, 'h80, 32'h3);
    rd(0, 'h88, d); chk(d[16] == 1'b1, "R10 command error", d, 32'h10000);
    rd(0, 'h80, d); chk(d == 32'h1, "R10 command bit kept", d, 32'h1);

    // Random phase
    for (int n = 0; n < 6000; n++) begin
      int ch, off;
      ch  = $urandom_range(0, NUM_CH - 1);
      off = offs[$urandom_range(0, 13)];
      bus_addr  = AW'((ch << 13) | off);
      bus_wr    = ($urandom_range(0, 2) == 0);
      bus_wdata = $urandom;
      if (off == 'h84) bus_wdata = ($urandom_range(0, 9) < 7) ? 32'h1 : 32'($urandom_range(0, 3));
      if (off == 'h80 && $urandom_range(0, 7) != 0) bus_wdata = 32'h1;
      if (off == 'h9C && $urandom_range(0, 3) != 0) bus_wdata = bus_wdata & 32'h3FF;
      for (int c = 0; c < NUM_CH; c++) begin
        eng_start[c]    = ($urandom_range(0, 5) == 0);
        eng_eol[c]      = ($urandom_range(0, 15) == 0);
        eng_desc_eol[c] = ($urandom_range(0, 1) == 0);
        eng_intr[c]     = ($urandom_range(0, 3) == 0) ? INTR_W'($urandom) : '0;
        eng_src_we[c]   = ($urandom_range(0, 7) == 0);
        eng_ptr_we[c]   = ($urandom_range(0, 7) == 0);
      end
      eng_src = 8'($urandom); eng_data_ptr = $urandom; eng_buf_ptr = $urandom;
      tick();
    end
    bus_wr = 1'b0; eng_start = '0; eng_eol = '0; eng_intr = '0;
    eng_src_we = '0; eng_ptr_we = '0;
    tick(); tick();
    finish_run();
  end
endmodule